// File: doc/BRIEF.md
# O-QPSK Chip Spreader with Offset I/Q Split

This block sits on the transmit side of a 2.4 GHz low-rate wireless modem. It accepts bytes over a valid/ready handshake and cuts each byte into two 4-bit data symbols, low nibble first. It expands every symbol into a fixed 32-chip pseudo-noise word. It then deals the chips alternately onto an in-phase rail and a quadrature rail.

A chip-enable input sets the chip time Tc. Each enable pulse sends out exactly one chip. An even-numbered chip updates the I rail and an odd-numbered chip updates the Q rail. Each rail therefore holds its value for two chip times, and the Q rail changes one chip time after the I rail. That gives the half-symbol-chip offset of offset QPSK. At 2 Mchip/s the enable pulses once every 500 ns.

The next byte is taken in during the same clock as the last chip of the current byte. While data keeps arriving, the chip stream has no gaps. Pulse shaping, digital-to-analog conversion and everything analog are downstream of this block.

Top module: `oqpsk_chip_spreader`

## Requirements
- R1: During and right after reset: `in_ready`=1, `busy`=0, `chip_stb`=0, `i_chip`=0, `q_chip`=0.
- R2: A byte is taken only on a clock where `in_valid` and `in_ready` are both high. `busy` is high from the next clock until the last chip of that byte has been sent. `in_data` is ignored on every other clock.
- R3: The symbol in bits 3:0 of a byte is spread first and the symbol in bits 7:4 second. Chips go out in the order c0 to c31.
- R4: Symbol 0 spreads to c0..c31 = 0xD9C3522E, with c0 as the most significant bit of that hex word.
- R5: For symbols 1 to 7, chip n equals chip (n − 4k) mod 32 of symbol 0, where k is the symbol value (for symbol 1, 0xED9C3522).
- R6: For symbols 8 to 15, the word is that of the symbol minus 8 with every odd-indexed chip inverted (for symbol 8, 0x8C96077B).
- R7: A chip with an even index updates only `i_chip`. A chip with an odd index updates only `q_chip`. The other rail keeps its value.
- R8: One clock after a `chip_en` pulse that falls while a byte is held, `chip_stb` is high for one clock and the new chip is on its rail. No chip is sent without a `chip_en` pulse.
- R9: `in_ready` is low while a byte is held. The exception is the clock whose `chip_en` pulse sends that byte's last chip: `in_ready` is high there, so a following byte is spread with no missing chip slot.
- R10: With no byte held, `chip_en` pulses give no `chip_stb`, and both rails keep their values.
- R11: A reset in the middle of a byte discards that byte. The next byte starts again at chip c0 of its low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | One-clock pulse per chip time Tc |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Byte can be taken this clock |
| in_data | input | 8 | Byte to transmit |
| i_chip | output | 1 | In-phase chip rail |
| q_chip | output | 1 | Quadrature chip rail, one Tc behind I |
| chip_stb | output | 1 | A chip was placed on a rail this clock |
| busy | output | 1 | A byte is being spread |

## Verification
The byte patterns together cover all sixteen nibble values. Bytes 0x80 and 0x01 separate symbol 0 from its rotated form (symbol 1) and from its odd-inverted form (symbol 8), and they show which nibble goes first. The chip enable is run at every clock, every third clock and every fifth clock, and in some cycles `in_valid` is dropped while junk is driven on `in_data`. This shows that back-to-back bytes leave no missing chip slot at either cadence and that data not taken is ignored. Directed cases cover idle enable pulses, which must not move the rails, and a reset partway through a byte.

// File: rtl/oqpsk_spread_pkg.sv
package oqpsk_spread_pkg;

  localparam int SYM_W    = 4;
  localparam int CHIPS    = 32;
  localparam int CHIP_IW  = $clog2(CHIPS);
  localparam int ROT_STEP = 4;

  // chip c0 is index 0 (leftmost)
  localparam logic [0:CHIPS-1] BASE_SEQ = 32'hD9C3522E;

  // chip n of a symbol: rotate the base word by ROT_STEP per step of the
  // low symbol bits, then invert the odd chips when the top bit is set
  function automatic logic chip_value(input logic [SYM_W-1:0]   sym,
                                      input logic [CHIP_IW-1:0] idx);
    logic [CHIP_IW-1:0] src;
    logic               b;
    src = idx - CHIP_IW'(int'(sym[SYM_W-2:0]) * ROT_STEP);
    b   = BASE_SEQ[src];
    if (sym[SYM_W-1] && idx[0]) b = ~b;
    return b;
  endfunction

  // odd chip index goes to the quadrature rail
  function automatic logic chip_on_q(input logic [CHIP_IW-1:0] idx);
    return idx[0];
  endfunction

endpackage

// File: rtl/osp_byte_hold.sv
module osp_byte_hold #(
  parameter int BYTE_W = 8,
  parameter int SYM_W  = 4,
  localparam int SYMS  = BYTE_W / SYM_W,
  localparam int SEL_W = (SYMS > 1) ? $clog2(SYMS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              release_i,
  input  logic [SEL_W-1:0]  sym_sel,
  output logic              in_ready,
  output logic              have_byte,
  output logic [SYM_W-1:0]  sym
);

  logic [BYTE_W-1:0] byte_q;
  logic              have_q;
  logic              take;

  assign in_ready  = !have_q || release_i;
  assign take      = in_valid && in_ready;
  assign have_byte = have_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      have_q <= 1'b0;
    end else if (take) begin
      byte_q <= in_data;
      have_q <= 1'b1;
    end else if (release_i) begin
      have_q <= 1'b0;
    end
  end

  // nibble select, lowest nibble first
  always_comb begin
    sym = '0;
    for (int s = 0; s < SYMS; s++) begin
      if (sym_sel == SEL_W'(s)) sym = byte_q[s*SYM_W +: SYM_W];
    end
  end

endmodule

// File: rtl/osp_chip_counter.sv
module osp_chip_counter #(
  parameter int TOTAL = 64,
  localparam int CNT_W = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TOTAL - 1);

  assign last_o = step && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (step)   cnt <= last_o ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/osp_rail_split.sv
module osp_rail_split (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic chip_bit,
  input  logic on_q,
  output logic i_chip,
  output logic q_chip,
  output logic chip_stb
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_chip   <= 1'b0;
      q_chip   <= 1'b0;
      chip_stb <= 1'b0;
    end else begin
      chip_stb <= step;
      if (step) begin
        if (on_q) q_chip <= chip_bit;
        else      i_chip <= chip_bit;
      end
    end
  end

endmodule

// File: rtl/oqpsk_chip_spreader.sv
module oqpsk_chip_spreader
  import oqpsk_spread_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              i_chip,
  output logic              q_chip,
  output logic              chip_stb,
  output logic              busy
);

  localparam int SYMS  = BYTE_W / SYM_W;
  localparam int SEL_W = (SYMS > 1) ? $clog2(SYMS) : 1;
  localparam int TOTAL = SYMS * CHIPS;
  localparam int CNT_W = $clog2(TOTAL);

  // named internal events
  logic               have_byte;
  logic               step;
  logic               last_chip;
  logic               emit_q;
  logic               chip_bit;
  logic [SYM_W-1:0]   sym_now;
  logic [CNT_W-1:0]   cnt;
  logic [CHIP_IW-1:0] chip_idx;
  logic [SEL_W-1:0]   sym_sel;

  assign step     = chip_en && have_byte;
  assign chip_idx = cnt[CHIP_IW-1:0];
  assign sym_sel  = SEL_W'(cnt >> CHIP_IW);
  assign chip_bit = chip_value(sym_now, chip_idx);
  assign emit_q   = step && chip_on_q(chip_idx);
  assign busy     = have_byte;

  osp_byte_hold #(.BYTE_W(BYTE_W), .SYM_W(SYM_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .release_i (last_chip),
    .sym_sel   (sym_sel),
    .in_ready  (in_ready),
    .have_byte (have_byte),
    .sym       (sym_now)
  );

  osp_chip_counter #(.TOTAL(TOTAL)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .cnt    (cnt),
    .last_o (last_chip)
  );

  osp_rail_split u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .chip_bit (chip_bit),
    .on_q     (chip_on_q(chip_idx)),
    .i_chip   (i_chip),
    .q_chip   (q_chip),
    .chip_stb (chip_stb)
  );

endmodule

// File: rtl/osp_checker.sv
module osp_checker (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic chip_stb,
  input logic i_chip,
  input logic q_chip,
  input logic emit_q
);

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);                                            // R9

  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !chip_en |-> !in_ready);                                // R9

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy);                                 // R2

  AST_STB_FROM_CE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb |-> $past(chip_en) && $past(busy));                    // R8

  AST_Q_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb && $past(emit_q) |-> $stable(i_chip));                 // R7

  AST_I_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb && !$past(emit_q) |-> $stable(q_chip));                // R7

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb |-> $stable(i_chip) && $stable(q_chip));              // R10

endmodule

bind oqpsk_chip_spreader osp_checker u_osp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en  (chip_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .chip_stb (chip_stb),
  .i_chip   (i_chip),
  .q_chip   (q_chip),
  .emit_q   (emit_q)
);

// File: tb/tb_oqpsk_chip_spreader.sv
`timescale 1ns/1ps
module tb_oqpsk_chip_spreader;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       chip_en;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       i_chip, q_chip, chip_stb, busy;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  closed = 0;

  logic       exp_i = 1'b0, exp_q = 1'b0;
  logic [0:31] cap [0:7];
  logic [7:0]  sb  [0:3];

  localparam logic [0:31] REF0 = 32'hD9C3522E;

  // {chip_en period, valid-drop modulus (0 = none), four bytes}
  localparam logic [39:0] VEC [0:3] = '{
    {4'd1, 4'd0, 8'h80, 8'h01, 8'hFF, 8'h7E},
    {4'd3, 4'd0, 8'h00, 8'h11, 8'hC3, 8'h5A},
    {4'd2, 4'd3, 8'hF0, 8'h0F, 8'h96, 8'hE7},
    {4'd5, 4'd0, 8'h24, 8'hB8, 8'h6D, 8'h4A}
  };

  always #2 clk = ~clk;

  oqpsk_chip_spreader dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .i_chip(i_chip),
    .q_chip(q_chip), .chip_stb(chip_stb), .busy(busy)
  );

  // word of a symbol built by whole-vector rotate and xor mask
  function automatic logic [0:31] exp_word(input logic [3:0] s);
    logic [0:31] w;
    int k;
    k = int'(s[2:0]);
    w = (REF0 >> (4*k)) | (REF0 << (32 - 4*k));
    if (s[3]) w = w ^ 32'h5555_5555;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!closed) begin
      closed = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic run_stream(input int per, input int vgap);
    int acc = 0, emit = 0, cyc = 0;
    bit ce, vld, pend, took, erdy, c;
    int e, s;
    logic [3:0] sym;
    while (emit < 4*64 && cyc < 20000) begin
      ce  = (cyc % per) == 0;
      vld = (acc < 4) && (vgap == 0 || (cyc % vgap) != 1);
      chip_en  = ce;
      in_valid = vld;
      in_data  = vld ? sb[acc] : (8'hA5 ^ 8'(cyc));
      #1;
      pend = emit < acc*64;
      erdy = !pend || (ce && emit == acc*64 - 1);
      check(in_ready == erdy, "R9", "in_ready", in_ready, erdy);
      check(busy == pend, "R2", "busy", busy, pend);
      took = vld && in_ready;
      @(posedge clk); @(negedge clk);
      if (ce && pend) begin
        e   = emit;
        s   = e / 32;
        sym = (s % 2 == 0) ? sb[s/2][3:0] : sb[s/2][7:4];
        c   = exp_word(sym)[e % 32];
        if ((e % 2) == 0) exp_i = c; else exp_q = c;
        cap[s][e % 32] = ((e % 2) == 0) ? i_chip : q_chip;
        check(chip_stb == 1'b1, "R8", "chip_stb on chip", chip_stb, 1);
        check(i_chip == exp_i && q_chip == exp_q, "R7",
              "rails {i,q}", {i_chip, q_chip}, {exp_i, exp_q});
        emit++;
      end else begin
        check(chip_stb == 1'b0, "R8", "chip_stb without chip", chip_stb, 0);
      end
      if (took) acc++;
      cyc++;
    end
    chip_en = 0; in_valid = 0;
    check(emit == 4*64, "R2", "chips sent", emit, 4*64);
  endtask

  initial begin
    #(4*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; chip_en = 0; in_valid = 0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    check(in_ready && !busy && !chip_stb && !i_chip && !q_chip, "R1",
          "reset outputs", {in_ready, busy, chip_stb, i_chip, q_chip}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    check(in_ready && !busy && !chip_stb && !i_chip && !q_chip, "R1",
          "after release", {in_ready, busy, chip_stb, i_chip, q_chip}, 5'b10000);

    for (int v = 0; v < 4; v++) begin
      sb[0] = VEC[v][31:24]; sb[1] = VEC[v][23:16];
      sb[2] = VEC[v][15:8];  sb[3] = VEC[v][7:0];
      run_stream(int'(VEC[v][39:36]), int'(VEC[v][35:32]));
      if (v == 0) begin
        check(cap[0] == 32'hD9C3522E, "R4", "symbol 0 word", cap[0], 32'hD9C3522E);
        check(cap[1] == 32'h8C96077B, "R6", "symbol 8 word", cap[1], 32'h8C96077B);
        check(cap[2] == 32'hED9C3522, "R5", "symbol 1 word", cap[2], 32'hED9C3522);
        check(cap[3] == 32'hD9C3522E, "R3", "high nibble second", cap[3], 32'hD9C3522E);
      end
    end

    // idle enables: no chips, rails hold
    for (int k = 0; k < 6; k++) begin
      chip_en = 1; in_valid = 0; in_data = 8'hFF;
      @(posedge clk); @(negedge clk);
      check(!chip_stb && !busy, "R10", "idle strobe/busy", {chip_stb, busy}, 2'b00);
      check(i_chip == exp_i && q_chip == exp_q, "R10", "idle rails",
            {i_chip, q_chip}, {exp_i, exp_q});
    end
    chip_en = 0;

    // reset in the middle of a byte
    in_valid = 1; in_data = 8'h3C; chip_en = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    repeat (12) begin @(posedge clk); @(negedge clk); end
    chip_en = 0;
    rst_n = 0;
    #1;
    check(in_ready && !busy && !chip_stb && !i_chip && !q_chip, "R11",
          "mid-byte reset", {in_ready, busy, chip_stb, i_chip, q_chip}, 5'b10000);
    @(negedge clk);
    rst_n = 1;
    exp_i = 0; exp_q = 0;
    @(negedge clk);
    sb[0] = 8'h3C; sb[1] = 8'hD2; sb[2] = 8'h69; sb[3] = 8'hA7;
    run_stream(2, 0);
    check(cap[0] == exp_word(4'hC), "R11", "restart from c0", cap[0], exp_word(4'hC));

    summary();
  end

endmodule